// File: doc/BRIEF.md
# I2C Channel-Switch Control Register

This block is an I2C target that holds one 8-bit channel-enable word and drives eight switch-enable outputs from it. Each bit controls one channel on its own, so any set of channels may be on at once, including none and all. The upper five bits of the 7-bit target address are a parameter. The lower two bits come from a pair of strap pins, so four of these blocks can share one bus.

SCL and SDA first pass through a two-flop synchronizer. A filter then changes its output only after FILT identical samples in a row, which removes spikes shorter than that. A master writes the word with a normal write transfer, and every data byte is latched at its ACK. The word reads back MSB first. The enable outputs follow the word with break-before-make ordering. Channels being dropped go off first. Channels being added come on only after a gap of BBM_GAP + 1 system clocks. Channels kept in both words stay on throughout. An active-low asynchronous reset clears everything. A user who does not need this reset must tie it high.

Top module: `i2c_switch_ctrl`

## Requirements
- R1: The target ACKs an address byte only when its upper seven bits equal {ADDR_HI, addr_pin[1], addr_pin[0]}. For any other address it leaves SDA released, and the following data bytes change neither the word nor sw_en.
- R2: In a write, every data byte is ACKed (SDA pulled low in the ninth clock). The word takes the byte's value at the falling SCL edge that ends the byte's eighth bit, so the last byte of a transfer is the one that stays.
- R3: Bit i of the word enables channel i (sw_en[i]). Every 8-bit value is legal, and once settled sw_en equals the word.
- R4: A read address byte (LSB 1) makes the target send the word MSB first, once per byte, for as long as the master ACKs. After the master's NACK, SDA stays released.
- R5: While rst_n is low, the word, sw_en and sda_oe are all 0. A read after reset returns 0x00.
- R6: When an update both drops and adds channels, the dropped channels go off first, giving the value old & new. The added channels come on exactly BBM_GAP + 1 clocks later. No clock cycle has one enable rising while another falls.
- R7: A channel that is set in both the old word and the new word never goes low during the update.
- R8: When an update only drops channels or only adds them, and no gap is still running, sw_en changes once, straight to the new word.
- R9: SCL and SDA pulses shorter than FILT system clocks are ignored. They shift no extra bit and are not taken as START or STOP.
- R10: A STOP in the middle of a byte ends the transfer and leaves the word unchanged. A repeated START in the middle of a byte begins a new address phase, and the transfer that follows completes normally.
- R11: The target starts driving SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset; tie high if unused |
| addr_pin | input | 2 | Strapped low two bits of the target address |
| scl_i | input | 1 | Bus clock as seen at the pad |
| sda_i | input | 1 | Bus data as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| sw_en | output | 8 | Per-channel switch enables |

## Verification
Every bus edge reaches the state machine about six system clocks after the pin moves: two for the synchronizer, up to three for the filter, and one for the edge register. The bench therefore holds each SCL phase for ten clocks, and it samples SDA (ACK and read bits) in the middle of the SCL-high phase. The enable outputs are checked against the clock cycle on which they change. A monitor time-stamps every change of sw_en, and the bench then requires either one change straight to the new word, or the value old & new followed by the new word exactly BBM_GAP + 1 clocks later. Ignored stimuli are checked at the ports: a mismatched address must cause no sw_en change and must read back as the old word, and a filtered glitch or an aborted byte must leave the read-back value intact.

// File: rtl/i2c_switch_ctrl.sv
module i2c_switch_ctrl #(
  parameter logic [4:0] ADDR_HI = 5'b10011,
  parameter int FILT = 3,
  parameter int BBM_GAP = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] addr_pin,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [7:0] sw_en
);
  localparam int GW = $clog2(BBM_GAP + 1) + 1;

  typedef enum logic [2:0] {IDLE, ADDR, AACK, WR, WACK, RD, RACK} st_t;

  logic [1:0]      scl_s, sda_s;
  logic [FILT-1:0] scl_h, sda_h;
  logic            scl_f, sda_f, scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_s <= '1; sda_s <= '1;
      scl_h <= '1; sda_h <= '1;
      scl_f <= 1'b1; sda_f <= 1'b1;
      scl_p <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_i};
      sda_s <= {sda_s[0], sda_i};
      scl_h <= {scl_h[FILT-2:0], scl_s[1]};
      sda_h <= {sda_h[FILT-2:0], sda_s[1]};
      if (&scl_h) scl_f <= 1'b1; else if (~|scl_h) scl_f <= 1'b0;
      if (&sda_h) sda_f <= 1'b1; else if (~|sda_h) sda_f <= 1'b0;
      scl_p <= scl_f;
      sda_p <= sda_f;
    end

  wire start_c = scl_f & scl_p & sda_p & ~sda_f;
  wire stop_c  = scl_f & scl_p & ~sda_p & sda_f;
  wire rise    = scl_f & ~scl_p;
  wire fall    = ~scl_f & scl_p;

  st_t        st;
  logic [3:0] cnt;
  logic [7:0] sh, ctl_q;
  logic       rw;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; sh <= '0; rw <= 1'b0;
      sda_oe <= 1'b0; ctl_q <= '0;
    end else if (start_c) begin
      st <= ADDR; cnt <= '0; sda_oe <= 1'b0;
    end else if (stop_c) begin
      st <= IDLE; sda_oe <= 1'b0;
    end else begin
      case (st)
        ADDR, WR:
          if (rise) begin
            sh  <= {sh[6:0], sda_f};
            cnt <= cnt + 4'd1;
          end else if (fall && cnt == 4'd8) begin
            if (st == WR) begin
              st <= WACK; sda_oe <= 1'b1; ctl_q <= sh;
            end else if (sh[7:1] == {ADDR_HI, addr_pin}) begin
              st <= AACK; sda_oe <= 1'b1; rw <= sh[0];
            end else
              st <= IDLE;
          end
        AACK:
          if (fall) begin
            cnt <= '0;
            if (rw) begin
              st <= RD; sh <= ctl_q; sda_oe <= ~ctl_q[7];
            end else begin
              st <= WR; sda_oe <= 1'b0;
            end
          end
        WACK:
          if (fall) begin
            st <= WR; cnt <= '0; sda_oe <= 1'b0;
          end
        RD:
          if (fall) begin
            if (cnt == 4'd7) begin
              st <= RACK; sda_oe <= 1'b0;
            end else begin
              sh <= {sh[6:0], 1'b0}; sda_oe <= ~sh[6]; cnt <= cnt + 4'd1;
            end
          end
        RACK:
          if (rise && sda_f) st <= IDLE;
          else if (fall) begin
            st <= RD; cnt <= '0; sh <= ctl_q; sda_oe <= ~ctl_q[7];
          end
        default: st <= IDLE;
      endcase
    end

  logic [GW-1:0] gap;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sw_en <= '0; gap <= '0;
    end else if (|(sw_en & ~ctl_q)) begin
      sw_en <= sw_en & ctl_q;
      gap   <= GW'(BBM_GAP);
    end else if (gap != '0)
      gap <= gap - GW'(1);
    else
      sw_en <= ctl_q;
endmodule

// File: rtl/i2c_switch_ctrl_chk.sv
module i2c_switch_ctrl_chk #(
  parameter int BBM_GAP = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_f,
  input logic       sda_oe,
  input logic [7:0] ctl_q,
  input logic [7:0] sw_en
);
  localparam int AW = $clog2(BBM_GAP + 1) + 1;

  logic [7:0]    prev, prev_ctl;
  logic [AW-1:0] age;
  wire  [7:0]    up = sw_en & ~prev;
  wire  [7:0]    dn = prev & ~sw_en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prev <= '0; prev_ctl <= '0; age <= AW'(BBM_GAP);
    end else begin
      prev <= sw_en;
      prev_ctl <= ctl_q;
      if (|dn) age <= '0;
      else if (age < AW'(BBM_GAP)) age <= age + AW'(1);
    end

  // R6
  bbm_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|up) |-> (age >= AW'(BBM_GAP)));

  // R6
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((|up) && (|dn)));

  // R7
  keep_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dn & prev_ctl) == 8'h00);

  // R11
  ack_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_f);
endmodule

bind i2c_switch_ctrl i2c_switch_ctrl_chk #(.BBM_GAP(BBM_GAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_oe(sda_oe),
  .ctl_q(ctl_q), .sw_en(sw_en)
);

// File: tb/i2c_switch_ctrl_bench.sv
module i2c_switch_ctrl_bench;
  localparam int Q   = 10;
  localparam int GAP = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] addr_pin = 2'd0;
  logic       sda_oe;
  logic [7:0] sw_en;
  wire        sda_line = sda_m & ~sda_oe;

  i2c_switch_ctrl #(.BBM_GAP(GAP)) u_i2c_switch_ctrl (
    .clk(clk), .rst_n(rst_n), .addr_pin(addr_pin), .scl_i(scl_m),
    .sda_i(sda_line), .sda_oe(sda_oe), .sw_en(sw_en)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  int cyc = 0, nev = 0, bad_drive = 0;
  logic [7:0] prev_en = 8'h00;
  logic [7:0] ev_v [4];
  int         ev_c [4];
  logic       prev_oe = 1'b0;
  logic [7:0] exp_reg = 8'h00;

  always @(negedge clk) begin
    cyc++;
    if (sw_en !== prev_en) begin
      if (nev < 4) begin ev_v[nev] = sw_en; ev_c[nev] = cyc; end
      nev++;
      prev_en = sw_en;
    end
    if (sda_oe && !prev_oe && scl_m) bad_drive++;
    prev_oe = sda_oe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q(); q();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
  endtask

  task automatic put_bit_g(input logic b, input int kind);
    sda_m = b;
    repeat (3) @(negedge clk);
    if (kind == 1) begin scl_m = 1'b1; repeat (2) @(negedge clk); scl_m = 1'b0; end
    else repeat (2) @(negedge clk);
    repeat (Q - 5) @(negedge clk);
    scl_m = 1'b1;
    repeat (3) @(negedge clk);
    if (kind == 2) begin sda_m = ~b; repeat (2) @(negedge clk); sda_m = b; end
    else repeat (2) @(negedge clk);
    repeat (2 * Q - 5) @(negedge clk);
    scl_m = 1'b0; q();
  endtask

  task automatic get_ack(output logic ack);
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); ack = ~sda_line; q(); scl_m = 1'b0; q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_ack(ack);
  endtask

  task automatic recv_byte(input logic ack_m, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; q(); scl_m = 1'b1; q(); d[i] = sda_line; q(); scl_m = 1'b0; q();
    end
    sda_m = ~ack_m; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q(); sda_m = 1'b1;
  endtask

  function automatic logic [6:0] dev();
    return {5'b10011, addr_pin};
  endfunction

  task automatic wr(input logic [6:0] a, input logic [7:0] d, output logic aa, output logic da);
    bus_start(); send_byte({a, 1'b0}, aa); send_byte(d, da); bus_stop();
  endtask

  task automatic rd_chk(input string req);
    logic aa;
    logic [7:0] v;
    bus_start(); send_byte({dev(), 1'b1}, aa);
    recv_byte(1'b0, v); bus_stop();
    chk(req, {31'd0, aa}, 32'd1);
    chk(req, {24'd0, v}, {24'd0, exp_reg});
  endtask

  task automatic check_bbm(input logic [7:0] o, input logic [7:0] n);
    logic [7:0] off_b, on_b;
    off_b = o & ~n; on_b = n & ~o;
    if (off_b == 0 && on_b == 0) chk("R8 no change", nev, 0);
    else if (off_b != 0 && on_b != 0) begin
      chk("R6 two steps", nev, 2);
      chk("R7 kept channels", {24'd0, ev_v[0]}, {24'd0, o & n});
      chk("R6 final", {24'd0, ev_v[1]}, {24'd0, n});
      chk("R6 gap", ev_c[1] - ev_c[0], GAP + 1);
    end else begin
      chk("R8 single step", nev, 1);
      chk("R8 value", {24'd0, ev_v[0]}, {24'd0, n});
    end
  endtask

  task automatic do_write(input logic [7:0] d);
    logic aa, da;
    logic [7:0] o;
    o = exp_reg; nev = 0;
    wr(dev(), d, aa, da);
    repeat (10) @(negedge clk);
    chk("R1 ack", {31'd0, aa}, 32'd1);
    chk("R2 data ack", {31'd0, da}, 32'd1);
    check_bbm(o, d);
    chk("R3 sw_en", {24'd0, sw_en}, {24'd0, d});
    exp_reg = d;
  endtask

  function automatic logic [7:0] pat(input int k);
    logic [7:0] t [8] = '{8'h00, 8'hFF, 8'h0F, 8'hF0, 8'h55, 8'hAA, 8'h3C, 8'hC3};
    if (k < 8) return t[k];
    if (k < 16) return 8'(1 << (k - 8));
    return 8'((k * 73 + 29) ^ (k << 3));
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic aa, da;
    logic [7:0] v, v2;
    repeat (5) @(negedge clk);
    chk("R5 reset sw_en", {24'd0, sw_en}, 0);
    chk("R5 reset sda_oe", {31'd0, sda_oe}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    rd_chk("R5 read after reset");

    // R1: strap and address sweep
    for (int p = 0; p < 4; p++) begin
      for (int l = 0; l < 4; l++) begin
        logic [7:0] d;
        addr_pin = 2'(p);
        d = 8'((p * 4 + l) * 37 + 5);
        nev = 0;
        wr({5'b10011, 2'(l)}, d, aa, da);
        repeat (10) @(negedge clk);
        chk("R1 ack match", {31'd0, aa}, (p == l) ? 32'd1 : 32'd0);
        if (p == l) exp_reg = d;
        else chk("R1 no output change", nev, 0);
        chk("R1 word", {24'd0, sw_en}, {24'd0, exp_reg});
      end
    end
    addr_pin = 2'd2;
    nev = 0;
    wr(7'h0A, 8'h77, aa, da);
    chk("R1 upper bits mismatch", {31'd0, aa}, 0);
    rd_chk("R1 read after mismatch");

    // R2 R3 R6 R7 R8: value sweep with read-back
    for (int k = 0; k < 28; k++) begin
      do_write(pat(k));
      rd_chk("R2 read back");
    end

    // R2: multi-byte write keeps the last byte
    bus_start(); send_byte({dev(), 1'b0}, aa);
    send_byte(8'h81, da); chk("R2 byte1 ack", {31'd0, da}, 1);
    send_byte(8'h42, da); chk("R2 byte2 ack", {31'd0, da}, 1);
    bus_stop(); exp_reg = 8'h42;
    repeat (20) @(negedge clk);
    chk("R2 last byte", {24'd0, sw_en}, 32'h42);

    // R4: two-byte read, then NACK release
    bus_start(); send_byte({dev(), 1'b1}, aa);
    recv_byte(1'b1, v); recv_byte(1'b0, v2);
    chk("R4 read byte1", {24'd0, v}, 32'h42);
    chk("R4 read byte2", {24'd0, v2}, 32'h42);
    q();
    chk("R4 released after NACK", {31'd0, sda_line}, 1);
    bus_stop();

    // R10: STOP mid-byte, repeated START mid-byte
    bus_start(); send_byte({dev(), 1'b0}, aa);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
    bus_stop();
    rd_chk("R10 stop abort");
    bus_start(); send_byte({dev(), 1'b0}, aa);
    for (int i = 0; i < 5; i++) put_bit(1'b0);
    bus_start(); send_byte({dev(), 1'b0}, aa);
    chk("R10 restart ack", {31'd0, aa}, 1);
    send_byte(8'h3C, da); bus_stop(); exp_reg = 8'h3C;
    rd_chk("R10 restart write");

    // R9: glitches inside a data byte
    bus_start(); send_byte({dev(), 1'b0}, aa);
    v = 8'h96;
    for (int i = 7; i >= 0; i--) put_bit_g(v[i], (i % 2) + 1);
    get_ack(da); bus_stop();
    chk("R9 ack after glitches", {31'd0, da}, 1);
    exp_reg = 8'h96;
    rd_chk("R9 glitched byte");

    // R5: reset in operation
    do_write(8'hFF);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R5 async clear", {24'd0, sw_en}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1; exp_reg = 8'h00;
    repeat (5) @(negedge clk);
    rd_chk("R5 read after reset pulse");

    chk("R11 drive only with SCL low", bad_drive, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule